// File: doc/BRIEF.md
# Parallel FPGA Configuration Port Master

This block loads a target FPGA through its 8-bit parallel slave configuration port. The host issues a start command with a byte count. The block then runs the power-up program handshake. It takes configuration bytes over a valid/ready stream and strobes each byte into the target on a rising edge of the configuration clock. When all bytes are sent, it clocks dummy all-ones bytes until the target reports that configuration has completed. Each wait has its own timeout, counted in system clock cycles. Every failure ends in a one-cycle abort pulse and a sticky fail flag, and the controller returns to idle with the program line released.

The same port can read configuration data back. Chip select is held with write inactive, one clock pulse is given per byte, and the data bus is sampled after that pulse. Each sampled byte appears on a one-cycle valid output. The readback ends with chip select released and one extra clock pulse.

The configuration clock half-period, the timeouts, the settle time after chip select, the number of completion checks and the optional wait on the target's busy line are all parameters.

Top module: `cfg_port_master`

## Requirements
- R1: After reset, prog_o, cs_o, wr_o, in_ready_o, ok_o, fail_o, abort_o and rd_valid_o are 0, and cclk_o is 1.
- R2: A start with read_i=0 raises prog_o and holds it while init_i is 0. prog_o falls on the cycle after init_i is seen at 1.
- R3: If init_i stays 0, prog_o is high for exactly INIT_TO+1 cycles. The block then pulses abort_o for one cycle, sets fail_o and returns to idle with prog_o, cs_o and wr_o at 0.
- R4: After prog_o is released, cs_o and wr_o stay 0 while init_i and busy_i are both 1. Once that wait ends, cs_o and wr_o rise, and in_ready_o first rises SETTLE_CYC cycles later.
- R5: An accepted byte is driven on d_o. cclk_o then goes low for HALF_CYC cycles and high for HALF_CYC cycles. d_o does not change while cclk_o is low, so the target captures the byte on the rising edge.
- R6: With BUSY_CHECK=1, in_ready_o stays 0 after a byte's clock pulse for as long as busy_i is 1. If busy_i stays 1 for BUSY_TO cycles, the block aborts and sets fail_o as in R3.
- R7: If done_i is 1 while the block waits for a byte, loading stops with no failure. No further bytes are accepted, and the block moves on to the trailing clocks.
- R8: If init_i is 1 while the block waits for a byte, the block aborts and sets fail_o.
- R9: After loading, cs_o and wr_o are 0 and each trailing clock pulse carries d_o=8'hFF. ok_o is set on the 9th consecutive check with done_i=1 and init_i=0. With those inputs held from the end of loading, exactly 8 trailing pulses are given.
- R10: If those trailing checks do not succeed within CFG_TO cycles of the end of loading, the block aborts and sets fail_o.
- R11: A start with read_i=1 raises cs_o with wr_o at 0 and gives len_i clock pulses. d_i is sampled at the end of each pulse's high half and presented on rd_data_o with a one-cycle rd_valid_o. cs_o then falls, one more clock pulse is given, and ok_o is set.
- R12: ok_o and fail_o are never both 1. Both hold their value until the next start, which clears them.
- R13: in_ready_o is 1 only while cs_o and wr_o are 1. Exactly len_i bytes are accepted per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, sampled in idle |
| read_i | input | 1 | 1 = readback, 0 = load |
| len_i | input | LEN_W | Number of bytes to move |
| in_valid_i | input | 1 | Host byte valid |
| in_data_i | input | 8 | Host configuration byte |
| in_ready_o | output | 1 | Host byte accepted when high with valid |
| rd_valid_o | output | 1 | Readback byte valid (one cycle) |
| rd_data_o | output | 8 | Readback byte |
| ok_o | output | 1 | Sticky success flag |
| fail_o | output | 1 | Sticky failure flag |
| abort_o | output | 1 | One-cycle abort pulse |
| prog_o | output | 1 | Program request to the target, 1 = asserted |
| cclk_o | output | 1 | Configuration clock, idles high |
| cs_o | output | 1 | Target chip select, 1 = asserted |
| wr_o | output | 1 | Target write enable, 1 = write |
| d_o | output | 8 | Configuration data to the target |
| d_i | input | 8 | Data from the target during readback |
| init_i | input | 1 | Target init status, 1 = asserted |
| done_i | input | 1 | Target done status, 1 = done |
| busy_i | input | 1 | Target busy status, 1 = busy |

## Verification
The bench measures the program pulse length on an init timeout exactly, so a timer that is off by one makes the abort too early or too late. It holds busy_i across a byte's clock pulse and checks that no new byte is offered. A design that ignores busy would overrun the target, and one that misses its timeout would hang. It raises done_i part way through a load and at the end of a load. Too few or too many trailing all-ones pulses, or a design that keeps accepting bytes after early completion, shows up in the pulse and byte counts. The readback run checks the byte order against a pattern that changes on every falling clock, so sampling on the wrong edge shifts the data by one byte.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_W_INIT, ST_W_REL, ST_SETTLE, ST_LOAD,
    ST_CLK_LO, ST_CLK_HI, ST_W_BUSY, ST_POST_CHK, ST_RB_NEXT
  } cfg_st_e;

  // what a finished clock pulse returns to
  typedef enum logic [1:0] {
    PH_LOAD, PH_POST, PH_RB, PH_RBEND
  } cfg_ph_e;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/cfg_tick_cnt.sv
module cfg_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!hit_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_out_dec.sv
module cfg_out_dec
  import cfg_port_pkg::*;
(
  input  cfg_st_e st_i,
  input  cfg_ph_e ph_i,
  output logic    prog_o,
  output logic    cclk_o,
  output logic    cs_o,
  output logic    wr_o
);
  logic in_load, in_rb;

  always_comb begin
    in_load = (ph_i == PH_LOAD) &&
              (st_i inside {ST_SETTLE, ST_LOAD, ST_CLK_LO, ST_CLK_HI, ST_W_BUSY});
    in_rb   = (ph_i == PH_RB) && (st_i inside {ST_RB_NEXT, ST_CLK_LO, ST_CLK_HI});
  end

  assign prog_o = (st_i == ST_W_INIT);
  assign cclk_o = (st_i != ST_CLK_LO);
  assign cs_o   = in_load || in_rb;
  assign wr_o   = in_load;
endmodule

// File: rtl/cfg_port_master.sv
module cfg_port_master
  import cfg_port_pkg::*;
#(
  parameter int LEN_W       = 24,
  parameter int HALF_CYC    = 2,
  parameter int INIT_TO     = 50_000_000,
  parameter int BUSY_TO     = 500_000,
  parameter int CFG_TO      = 20_000_000,
  parameter int SETTLE_CYC  = 1_000_000,
  parameter int DONE_CHECKS = 8,
  parameter bit BUSY_CHECK  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             read_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             ok_o,
  output logic             fail_o,
  output logic             abort_o,
  output logic             prog_o,
  output logic             cclk_o,
  output logic             cs_o,
  output logic             wr_o,
  output logic [7:0]       d_o,
  input  logic [7:0]       d_i,
  input  logic             init_i,
  input  logic             done_i,
  input  logic             busy_i
);
  localparam int TMAX = max4(INIT_TO, BUSY_TO, CFG_TO, SETTLE_CYC);
  localparam int TW   = $clog2(TMAX + 2);
  localparam int HW   = $clog2(HALF_CYC + 1) + 1;
  localparam int SW   = $clog2(DONE_CHECKS + 2);

  cfg_st_e st_q, st_d;
  cfg_ph_e ph_q, ph_d;

  logic [LEN_W-1:0] cnt_q, len_q;
  logic [SW-1:0]    streak_q;
  logic [7:0]       d_q, rd_q;
  logic             rdv_q, ok_q, fail_q, abort_q;

  logic tmr_clr, tmr_hit, half_clr, half_hit;
  logic [TW-1:0] tmr_lim;
  logic take, fail_ev, ok_ev, rb_smp, ff_load, streak_inc, streak_clr, begin_ev;
  logic bw_en, good_chk;

  generate
    if (BUSY_CHECK) begin : g_busy_wait
      assign bw_en = 1'b1;
    end else begin : g_no_busy_wait
      assign bw_en = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (st_q)
      ST_W_INIT, ST_W_REL: tmr_lim = TW'(INIT_TO);
      ST_SETTLE:           tmr_lim = TW'(SETTLE_CYC - 1);
      ST_W_BUSY:           tmr_lim = TW'(BUSY_TO);
      default:             tmr_lim = TW'(CFG_TO);
    endcase
  end

  cfg_tick_cnt #(.W(TW)) u_phase_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .lim_i(tmr_lim), .hit_o(tmr_hit)
  );

  cfg_tick_cnt #(.W(HW)) u_half_tmr (
    .clk_i, .rst_ni, .clr_i(half_clr), .lim_i(HW'(HALF_CYC - 1)), .hit_o(half_hit)
  );

  cfg_out_dec u_out_dec (
    .st_i(st_q), .ph_i(ph_q), .prog_o, .cclk_o, .cs_o, .wr_o
  );

  assign good_chk = done_i && !init_i;

  always_comb begin
    st_d = st_q;  ph_d = ph_q;
    tmr_clr = 1'b0;  half_clr = 1'b0;  take = 1'b0;  fail_ev = 1'b0;
    ok_ev = 1'b0;  rb_smp = 1'b0;  ff_load = 1'b0;  begin_ev = 1'b0;
    streak_inc = 1'b0;  streak_clr = 1'b0;  in_ready_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        begin_ev = 1'b1;
        tmr_clr  = 1'b1;
        if (read_i) begin ph_d = PH_RB;   st_d = ST_RB_NEXT; end
        else        begin ph_d = PH_LOAD; st_d = ST_W_INIT;  end
      end
      ST_W_INIT:
        if (init_i)       begin st_d = ST_W_REL; tmr_clr = 1'b1; end
        else if (tmr_hit) fail_ev = 1'b1;
      ST_W_REL:
        if (!(init_i && busy_i)) begin st_d = ST_SETTLE; tmr_clr = 1'b1; end
        else if (tmr_hit)        fail_ev = 1'b1;
      ST_SETTLE: if (tmr_hit) st_d = ST_LOAD;
      ST_LOAD:
        if ((cnt_q == len_q) || done_i) begin
          st_d = ST_POST_CHK; ph_d = PH_POST; tmr_clr = 1'b1; streak_clr = 1'b1;
        end else if (init_i) begin
          fail_ev = 1'b1;
        end else begin
          in_ready_o = 1'b1;
          if (in_valid_i) begin take = 1'b1; st_d = ST_CLK_LO; half_clr = 1'b1; end
        end
      ST_CLK_LO: if (half_hit) begin st_d = ST_CLK_HI; half_clr = 1'b1; end
      ST_CLK_HI: if (half_hit) begin
        unique case (ph_q)
          PH_LOAD: if (bw_en) begin st_d = ST_W_BUSY; tmr_clr = 1'b1; end
                   else       st_d = ST_LOAD;
          PH_POST: st_d = ST_POST_CHK;
          PH_RB:   begin rb_smp = 1'b1; st_d = ST_RB_NEXT; end
          default: begin ok_ev = 1'b1; st_d = ST_IDLE; end
        endcase
      end
      ST_W_BUSY:
        if (!busy_i)      st_d = ST_LOAD;
        else if (tmr_hit) fail_ev = 1'b1;
      ST_POST_CHK:
        if (good_chk && (streak_q == SW'(DONE_CHECKS))) begin
          ok_ev = 1'b1; st_d = ST_IDLE;
        end else begin
          if (good_chk) streak_inc = 1'b1;
          else          streak_clr = 1'b1;
          if (tmr_hit) fail_ev = 1'b1;
          else begin ff_load = 1'b1; st_d = ST_CLK_LO; half_clr = 1'b1; end
        end
      ST_RB_NEXT: begin
        st_d = ST_CLK_LO; half_clr = 1'b1;
        if (cnt_q == len_q) ph_d = PH_RBEND;
      end
      default: st_d = ST_IDLE;
    endcase
    if (fail_ev) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  ph_q <= PH_LOAD;
      cnt_q <= '0;  len_q <= '0;  streak_q <= '0;
      d_q <= 8'hFF;  rd_q <= '0;  rdv_q <= 1'b0;
      ok_q <= 1'b0;  fail_q <= 1'b0;  abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      rdv_q   <= rb_smp;
      abort_q <= fail_ev;
      if (begin_ev) begin
        len_q <= len_i; cnt_q <= '0; ok_q <= 1'b0; fail_q <= 1'b0;
      end else if (take || rb_smp) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (streak_clr)      streak_q <= '0;
      else if (streak_inc) streak_q <= streak_q + 1'b1;
      if (take)         d_q <= in_data_i;
      else if (ff_load) d_q <= 8'hFF;
      if (rb_smp) rd_q <= d_i;
      if (ok_ev)   ok_q   <= 1'b1;
      if (fail_ev) fail_q <= 1'b1;
    end
  end

  assign d_o        = d_q;
  assign rd_data_o  = rd_q;
  assign rd_valid_o = rdv_q;
  assign ok_o       = ok_q;
  assign fail_o     = fail_q;
  assign abort_o    = abort_q;

  p_abort_fail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> fail_o);
  p_abort_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!prog_o && !cs_o && !wr_o));
  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cclk_o && $past(!cclk_o)) |-> $stable(d_o));
  p_ready_ctrl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (cs_o && wr_o && !prog_o));
  p_flag_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && fail_o));
  p_rd_dir_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (cs_o && !wr_o));
  p_busy_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_W_BUSY && busy_i) |=> !in_ready_o);
endmodule

// File: tb/tb_cfg_port_master.sv
module tb_cfg_port_master;
  localparam int HALF = 2, ITO = 20, BTO = 12, CTO = 150, SET = 5, DCH = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, read_i = 0, in_valid_i = 0;
  logic [7:0] len_i = '0, in_data_i = '0, d_i = '0;
  logic init_i = 0, done_i = 0, busy_i = 0;
  logic in_ready_o, rd_valid_o, ok_o, fail_o, abort_o, prog_o, cclk_o, cs_o, wr_o;
  logic [7:0] rd_data_o, d_o;

  cfg_port_master #(.LEN_W(8), .HALF_CYC(HALF), .INIT_TO(ITO), .BUSY_TO(BTO),
    .CFG_TO(CTO), .SETTLE_CYC(SET), .DONE_CHECKS(DCH), .BUSY_CHECK(1'b1)) dut (
    .clk_i(clk), .rst_ni, .start_i, .read_i, .len_i, .in_valid_i, .in_data_i,
    .in_ready_o, .rd_valid_o, .rd_data_o, .ok_o, .fail_o, .abort_o, .prog_o,
    .cclk_o, .cs_o, .wr_o, .d_o, .d_i, .init_i, .done_i, .busy_i);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] cap [0:15];
  int cap_n = 0, post_clks = 0, post_bad = 0, rb_clks = 0, rb_end = 0, rb_k = 0;
  bit mode_rd = 0;

  function automatic logic [7:0] wpat(int i); return 8'(8'hC3 + i * 29); endfunction
  function automatic logic [7:0] rpat(int i); return 8'(8'h5A ^ (i * 37)); endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // target-side monitor
  always @(posedge cclk_o) begin
    if (cs_o && wr_o) begin
      if (cap_n < 16) cap[cap_n] = d_o;
      cap_n++;
    end else if (cs_o) rb_clks++;
    else if (mode_rd) rb_end++;
    else begin
      post_clks++;
      if (d_o != 8'hFF) post_bad++;
    end
  end

  always @(negedge cclk_o) if (cs_o && !wr_o) begin d_i = rpat(rb_k); rb_k++; end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr_mon();
    cap_n = 0; post_clks = 0; post_bad = 0; rb_clks = 0; rb_end = 0; rb_k = 0;
  endtask

  task automatic pulse_start(bit rd, int len);
    clr_mon();
    mode_rd = rd;
    @(negedge clk); start_i = 1; read_i = rd; len_i = 8'(len);
    @(negedge clk); start_i = 0;
    chk(!ok_o && !fail_o, "R12", "flags cleared by start", int'({ok_o, fail_o}), 0);
  endtask

  task automatic wait_end(output int aborts);
    aborts = 0;
    while (!(ok_o || fail_o)) begin
      @(negedge clk);
      if (abort_o) aborts++;
    end
  endtask

  task automatic bring_up();
    int n;
    for (int i = 0; i < 3; i++) begin
      chk(prog_o == 1, "R2", "prog held while init low", prog_o, 1);
      @(negedge clk);
    end
    busy_i = 1; init_i = 1;
    @(negedge clk);
    chk(prog_o == 0, "R2", "prog released after init", prog_o, 0);
    for (int i = 0; i < 3; i++) begin
      chk(!cs_o && !wr_o, "R4", "cs/wr low while init&busy", int'({cs_o, wr_o}), 0);
      @(negedge clk);
    end
    init_i = 0; busy_i = 0;
    while (!cs_o) @(negedge clk);
    n = 0;
    while (!in_ready_o && n < 100) begin @(negedge clk); n++; end
    chk(n == SET && wr_o, "R4", "settle cycles before ready", n, SET);
  endtask

  task automatic send_bytes(int n, int busy_idx);
    int sent = 0;
    bit rdy_seen;
    while (sent < n) begin
      if (in_ready_o) begin
        in_valid_i = 1; in_data_i = wpat(sent);
        @(negedge clk);
        in_valid_i = 0;
        if (sent == busy_idx) begin
          busy_i = 1; rdy_seen = 0;
          for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (in_ready_o) rdy_seen = 1;
          end
          busy_i = 0;
          chk(!rdy_seen, "R6", "no ready while busy", rdy_seen, 0);
        end
        sent++;
      end else @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(!prog_o && !cs_o && !wr_o && cclk_o, "R1", "control pins at reset",
        int'({prog_o, cs_o, wr_o, cclk_o}), 1);
    chk(!ok_o && !fail_o && !abort_o && !in_ready_o && !rd_valid_o, "R1", "flags at reset",
        int'({ok_o, fail_o, abort_o, in_ready_o, rd_valid_o}), 0);
  endtask

  task automatic t_load_ok();
    int ab; bit mism = 0;
    pulse_start(0, 4);
    bring_up();
    send_bytes(4, 1);
    done_i = 1;
    wait_end(ab);
    for (int i = 0; i < 4; i++) if (cap[i] != wpat(i)) mism = 1;
    chk(cap_n == 4, "R13", "bytes accepted equals length", cap_n, 4);
    chk(!mism, "R5", "captured data matches", mism, 0);
    chk(post_clks == 8 && post_bad == 0, "R9", "trailing FF pulses", post_clks, 8);
    chk(ok_o && !fail_o && ab == 0, "R9", "ok after completion checks", int'({ok_o, fail_o}), 2);
    chk(!cs_o && !wr_o, "R9", "cs/wr released", int'({cs_o, wr_o}), 0);
    done_i = 0;
  endtask

  task automatic t_init_timeout();
    int n = 0, ab;
    pulse_start(0, 2);
    while (prog_o && n < 200) begin n++; @(negedge clk); if (abort_o) ab++; end
    chk(n == ITO + 1, "R3", "prog high cycles before timeout", n, ITO + 1);
    chk(fail_o && abort_o && !prog_o && !cs_o, "R3", "abort and fail",
        int'({fail_o, abort_o, prog_o, cs_o}), 12);
    @(negedge clk);
    chk(!abort_o && fail_o, "R3", "abort one cycle, fail sticky", int'({abort_o, fail_o}), 1);
  endtask

  task automatic t_early_done();
    int ab;
    pulse_start(0, 4);
    bring_up();
    send_bytes(2, -1);
    done_i = 1;
    wait_end(ab);
    chk(cap_n == 2, "R7", "no bytes after early done", cap_n, 2);
    chk(ok_o && ab == 0 && post_clks == 8, "R7", "early done ends normally", post_clks, 8);
    done_i = 0;
  endtask

  task automatic t_init_load();
    int ab;
    pulse_start(0, 4);
    bring_up();
    send_bytes(1, -1);
    init_i = 1;
    wait_end(ab);
    chk(fail_o && ab == 1 && cap_n == 1, "R8", "init during load aborts", ab, 1);
    chk(!cs_o && !wr_o && !prog_o, "R8", "pins released after abort", int'({cs_o, wr_o, prog_o}), 0);
    init_i = 0;
  endtask

  task automatic t_busy_to();
    int ab;
    pulse_start(0, 3);
    bring_up();
    in_valid_i = 1; in_data_i = wpat(0);
    @(negedge clk); in_valid_i = 0; busy_i = 1;
    wait_end(ab);
    chk(fail_o && ab == 1 && cap_n == 1, "R6", "busy timeout aborts", ab, 1);
    busy_i = 0;
  endtask

  task automatic t_cfg_to();
    int ab;
    pulse_start(0, 1);
    bring_up();
    send_bytes(1, -1);
    wait_end(ab);
    chk(fail_o && !ok_o && ab == 1, "R10", "completion timeout aborts", ab, 1);
    chk(post_clks > 10 && post_bad == 0, "R10", "dummy clocks before timeout", post_clks, 11);
  endtask

  task automatic t_readback();
    int ab, n = 0; bit mism = 0, wr_seen = 0;
    logic [7:0] rd [0:7];
    pulse_start(1, 3);
    chk(cs_o && !wr_o, "R11", "cs high, wr low in readback", int'({cs_o, wr_o}), 2);
    while (!(ok_o || fail_o)) begin
      @(negedge clk);
      if (wr_o) wr_seen = 1;
      if (rd_valid_o) begin if (n < 8) rd[n] = rd_data_o; n++; end
    end
    for (int i = 0; i < 3; i++) if (rd[i] != rpat(i)) mism = 1;
    chk(n == 3 && !mism, "R11", "readback bytes in order", n, 3);
    chk(rb_clks == 3 && rb_end == 1, "R11", "pulses then one with cs low", rb_end, 1);
    chk(ok_o && !cs_o && !wr_seen, "R11", "readback completes", int'({ok_o, cs_o}), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_load_ok();
    t_init_timeout();
    t_early_done();
    t_init_load();
    t_busy_to();
    t_cfg_to();
    t_readback();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule